// File: doc/BRIEF.md
# Binary Phase-Coded Radar Pulse Generator

This block produces a repeating radar pulse whose carrier is a constant-frequency sine taken from a phase-accumulator lookup. Inside each pulse the carrier is cut into equal chips, and each chip is passed through unchanged or sign-inverted (a 0° or 180° phase step) according to one of seven built-in Barker codes. A host supplies the code selection, the carrier tuning word, the chip length, the pulse length and the repetition interval, all in clock cycles. The host works out the chip length as pulse length divided by the code length. The block therefore needs no divider, and any cycles left over stretch the final chip.

Each enabled clock yields one sample. The output is a signed 14-bit word with a gate flag that marks the samples inside the pulse. The phase accumulator restarts at zero at the start of every repetition interval, so every pulse starts the carrier at phase 0. A new code selection takes effect only at an interval boundary. Dropping the enable aborts the current interval, and the next enable starts a fresh one.

Top module: `bpc_pulse_gen`

## Requirements
- R1: While `rst_n` is low, `gate_out` is 0 and `sample_out` is 0, whatever the other inputs do.
- R2: Number the rising edges that sample `enable` high from 0. Sample index j is the result of edge j, and its output is visible after edge j+3. Within each interval of `pri_len` samples, `gate_out` is 1 for the first `pulse_len` samples and 0 for the rest.
- R3: Sample k of an interval has phase (k × `tune_word`) mod 2^16. Let the table address a be its top 8 bits, u = a mod 128 and w = 4·u·(128−u). The carrier is then floor(w·8191/16384) for a < 128, and −floor(w·8192/16384) otherwise.
- R4: The code selection is read as follows: 0→length 2, 1→3, 2→4, 3→5, 4→7, 5→11, 6→13. The value 7 also gives length 13.
- R5: Write the chips in time order, with + meaning pass and − meaning invert. The codes are then: 2: ++, 3: ++−, 4: ++−+, 5: +++−+, 7: +++−−+−, 11: +++−−−+−−+−, 13: +++++−−++−+−+.
- R6: Sample k of a pulse belongs to chip min(floor(k / `chip_len`), N−1). Leftover cycles therefore extend the last chip.
- R7: Inverting the most negative carrier value (−8192) gives +8191 (saturation). Every other value is negated in two's complement.
- R8: When `gate_out` is 0, `sample_out` is 0.
- R9: A change of `code_sel` has effect only from the next interval start. The interval in progress keeps the code that was sampled on its first edge.
- R10: When `enable` is sampled low, the interval is abandoned and `gate_out` is 0 from the fourth edge after that. The next enable starts at sample 0 with phase 0 and chip 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low aborts and restarts the interval |
| code_sel | input | 3 | Barker length selection (see R4) |
| tune_word | input | 16 | Phase increment per sample |
| chip_len | input | 16 | Cycles per chip, at least 1 |
| pulse_len | input | 16 | Gated samples per interval |
| pri_len | input | 16 | Samples per repetition interval, at least 1 |
| sample_out | output | 14 | Signed coded carrier sample |
| gate_out | output | 1 | High for samples inside the pulse |

## Verification
The bench sweeps all eight selection codes with a pulse that is not a multiple of the chip length. A design that let the chip index run past the code end, or that wrapped to chip 0, would put wrong signs on the trailing samples. A tuning word of a quarter turn drives the negative peak into an inverted chip. Plain negation would wrap there and output −8192 instead of +8191. Other cases cover a code change in the middle of an interval, an abort in the middle of a pulse followed by a restart, and a pulse as long as the interval. These catch a code latched at once, an accumulator not cleared on restart, and a gate that drops for one cycle at the interval boundary.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
   localparam int IDX_W     = 4;
   localparam int MAX_CHIPS = 13;

   typedef enum logic [2:0] {
      CODE_L2  = 3'd0,
      CODE_L3  = 3'd1,
      CODE_L4  = 3'd2,
      CODE_L5  = 3'd3,
      CODE_L7  = 3'd4,
      CODE_L11 = 3'd5,
      CODE_L13 = 3'd6,
      CODE_ALT = 3'd7
   } code_sel_e;

   typedef logic [2**IDX_W-1:0] code_word_t;   // bit i set: chip i inverted

   function automatic logic [IDX_W-1:0] code_length(input code_sel_e s);
      case (s)
         CODE_L2:  return IDX_W'(2);
         CODE_L3:  return IDX_W'(3);
         CODE_L4:  return IDX_W'(4);
         CODE_L5:  return IDX_W'(5);
         CODE_L7:  return IDX_W'(7);
         CODE_L11: return IDX_W'(11);
         default:  return IDX_W'(13);
      endcase
   endfunction

   function automatic code_word_t code_pattern(input code_sel_e s);
      case (s)
         CODE_L2:  return code_word_t'(16'b0000_0000_0000_0000);
         CODE_L3:  return code_word_t'(16'b0000_0000_0000_0100);
         CODE_L4:  return code_word_t'(16'b0000_0000_0000_0100);
         CODE_L5:  return code_word_t'(16'b0000_0000_0000_1000);
         CODE_L7:  return code_word_t'(16'b0000_0000_0101_1000);
         CODE_L11: return code_word_t'(16'b0000_0101_1011_1000);
         default:  return code_word_t'(16'b0000_1010_0110_0000);
      endcase
   endfunction
endpackage

// File: rtl/bpc_sine_rom.sv
module bpc_sine_rom #(
   parameter int ADDR_W = 8,
   parameter int S_W    = 14,
   parameter bit FOLDED = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   output logic signed [S_W-1:0]   value
);
   localparam int HALF    = 2**(ADDR_W-1);
   localparam int SHIFT   = 2*ADDR_W-2;
   localparam int SHAPE_W = 2*ADDR_W-1;
   localparam int PROD_W  = SHAPE_W+S_W;
   localparam int POS_AMP = 2**(S_W-1)-1;
   localparam int NEG_AMP = 2**(S_W-1);

   if (SHIFT + S_W > 30) begin : g_bad_width
      $error("bpc_sine_rom: ADDR_W and S_W too wide for table arithmetic");
   end

   if (!FOLDED) begin : g_full
      logic signed [S_W-1:0] tbl [2**ADDR_W];
      for (genvar i = 0; i < 2**ADDR_W; i++) begin : g_ent
         localparam int U = i % HALF;
         localparam int W = 4*U*(HALF-U);
         localparam int V = (i < HALF) ? ((W*POS_AMP) >> SHIFT)
                                       : -((W*NEG_AMP) >> SHIFT);
         assign tbl[i] = S_W'(V);
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) value <= '0;
         else        value <= tbl[addr];
      end
   end else begin : g_folded
      logic [SHAPE_W-1:0] shape_tbl [HALF];
      for (genvar i = 0; i < HALF; i++) begin : g_ent
         assign shape_tbl[i] = SHAPE_W'(4*i*(HALF-i));
      end
      logic                  hi_half;
      logic [PROD_W-1:0]     prod;
      logic [S_W-1:0]        mag;
      logic signed [S_W:0]   smag;
      logic signed [S_W:0]   sval;
      always_comb begin
         hi_half = addr[ADDR_W-1];
         prod    = PROD_W'(shape_tbl[addr[ADDR_W-2:0]])
                 * (hi_half ? PROD_W'(NEG_AMP) : PROD_W'(POS_AMP));
         mag     = S_W'(prod >> SHIFT);
         smag    = $signed({1'b0, mag});
         sval    = hi_half ? -smag : smag;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) value <= '0;
         else        value <= sval[S_W-1:0];
      end
   end
endmodule

// File: rtl/bpc_timing.sv
module bpc_timing
   import bpc_pkg::*;
#(
   parameter int PHASE_W = 16,
   parameter int CNT_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [2:0]         code_sel,
   input  logic [PHASE_W-1:0] tune_word,
   input  logic [CNT_W-1:0]   chip_len,
   input  logic [CNT_W-1:0]   pulse_len,
   input  logic [CNT_W-1:0]   pri_len,
   output logic               run,
   output logic               start,
   output logic               in_pulse,
   output logic [PHASE_W-1:0] phase,
   output logic               neg_chip,
   output logic [IDX_W-1:0]   chip_idx,
   output logic [IDX_W-1:0]   code_len
);
   if (CNT_W < 2 || PHASE_W < 4) begin : g_bad_cfg
      $error("bpc_timing: counter or phase width too small");
   end

   logic [CNT_W-1:0] pri_cnt;
   logic [CNT_W-1:0] chip_cnt;
   code_sel_e        sel_q;
   code_word_t       word;
   logic             last_chip;

   assign start     = enable && (!run || pri_cnt == pri_len - 1'b1);
   assign in_pulse  = run && (pri_cnt < pulse_len);
   assign code_len  = code_length(sel_q);
   assign word      = code_pattern(sel_q);
   assign neg_chip  = word[chip_idx];
   assign last_chip = (chip_idx == code_len - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= 1'b0;
         pri_cnt  <= '0;
         chip_cnt <= '0;
         chip_idx <= '0;
         phase    <= '0;
         sel_q    <= CODE_L2;
      end else begin
         run <= enable;
         if (!enable) begin
            pri_cnt  <= '0;
            chip_cnt <= '0;
            chip_idx <= '0;
            phase    <= '0;
         end else if (start) begin
            pri_cnt  <= '0;
            chip_cnt <= '0;
            chip_idx <= '0;
            phase    <= '0;
            sel_q    <= code_sel_e'(code_sel);
         end else begin
            pri_cnt <= pri_cnt + 1'b1;
            phase   <= phase + tune_word;
            if (!last_chip) begin
               if (chip_cnt == chip_len - 1'b1) begin
                  chip_cnt <= '0;
                  chip_idx <= chip_idx + 1'b1;
               end else begin
                  chip_cnt <= chip_cnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/bpc_sign_apply.sv
module bpc_sign_apply #(
   parameter int S_W = 14
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  gate_in,
   input  logic                  neg_in,
   input  logic signed [S_W-1:0] val_in,
   output logic signed [S_W-1:0] sample_out,
   output logic                  gate_out
);
   localparam logic signed [S_W-1:0] MOST_NEG = {1'b1, {(S_W-1){1'b0}}};
   localparam logic signed [S_W-1:0] MOST_POS = {1'b0, {(S_W-1){1'b1}}};

   logic signed [S_W-1:0] coded;

   always_comb begin
      if (!neg_in)                 coded = val_in;
      else if (val_in == MOST_NEG) coded = MOST_POS;
      else                         coded = -val_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_out <= '0;
         gate_out   <= 1'b0;
      end else begin
         sample_out <= gate_in ? coded : '0;
         gate_out   <= gate_in;
      end
   end
endmodule

// File: rtl/bpc_pulse_gen.sv
module bpc_pulse_gen
   import bpc_pkg::*;
#(
   parameter int PHASE_W = 16,
   parameter int ADDR_W  = 8,
   parameter int S_W     = 14,
   parameter int CNT_W   = 16,
   parameter bit FOLDED  = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  enable,
   input  logic [2:0]            code_sel,
   input  logic [PHASE_W-1:0]    tune_word,
   input  logic [CNT_W-1:0]      chip_len,
   input  logic [CNT_W-1:0]      pulse_len,
   input  logic [CNT_W-1:0]      pri_len,
   output logic signed [S_W-1:0] sample_out,
   output logic                  gate_out
);
   if (ADDR_W < 3 || ADDR_W > PHASE_W || S_W < 4) begin : g_bad_cfg
      $error("bpc_pulse_gen: illegal width combination");
   end

   logic                  t_run;
   logic                  t_start;
   logic                  t_in_pulse;
   logic [PHASE_W-1:0]    t_phase;
   logic                  t_neg;
   logic [IDX_W-1:0]      t_chip_idx;
   logic [IDX_W-1:0]      t_len;

   logic [ADDR_W-1:0]     s1_addr;
   logic                  s1_gate;
   logic                  s1_neg;
   logic                  s2_gate;
   logic                  s2_neg;
   logic signed [S_W-1:0] s2_val;

   bpc_timing #(.PHASE_W(PHASE_W), .CNT_W(CNT_W)) u_timing (
      .clk(clk), .rst_n(rst_n), .enable(enable), .code_sel(code_sel),
      .tune_word(tune_word), .chip_len(chip_len), .pulse_len(pulse_len),
      .pri_len(pri_len), .run(t_run), .start(t_start), .in_pulse(t_in_pulse),
      .phase(t_phase), .neg_chip(t_neg), .chip_idx(t_chip_idx), .code_len(t_len)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_addr <= '0;
         s1_gate <= 1'b0;
         s1_neg  <= 1'b0;
         s2_gate <= 1'b0;
         s2_neg  <= 1'b0;
      end else begin
         s1_addr <= t_phase[PHASE_W-1 -: ADDR_W];
         s1_gate <= t_in_pulse;
         s1_neg  <= t_neg;
         s2_gate <= s1_gate;
         s2_neg  <= s1_neg;
      end
   end

   bpc_sine_rom #(.ADDR_W(ADDR_W), .S_W(S_W), .FOLDED(FOLDED)) u_rom (
      .clk(clk), .rst_n(rst_n), .addr(s1_addr), .value(s2_val)
   );

   bpc_sign_apply #(.S_W(S_W)) u_sign (
      .clk(clk), .rst_n(rst_n), .gate_in(s2_gate), .neg_in(s2_neg),
      .val_in(s2_val), .sample_out(sample_out), .gate_out(gate_out)
   );
endmodule

// File: rtl/bpc_pulse_gen_chk.sv
module bpc_pulse_gen_chk #(
   parameter int S_W   = 14,
   parameter int CNT_W = 16,
   parameter int IDX_W = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  enable,
   input logic [CNT_W-1:0]      pulse_len,
   input logic [CNT_W-1:0]      pri_len,
   input logic signed [S_W-1:0] sample_out,
   input logic                  gate_out,
   input logic                  t_run,
   input logic                  t_start,
   input logic [IDX_W-1:0]      t_chip_idx,
   input logic [IDX_W-1:0]      t_len
);
   logic [2:0]     low_cnt;
   logic [CNT_W:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
         hi_cnt  <= '0;
      end else begin
         low_cnt <= enable ? 3'd0 : ((low_cnt == 3'd7) ? low_cnt : low_cnt + 3'd1);
         hi_cnt  <= gate_out ? hi_cnt + 1'b1 : '0;
      end
   end

   assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_out |-> sample_out == '0);

   assert_gate_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      low_cnt >= 3'd4 |-> !gate_out);

   assert_gate_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_out && (pulse_len < pri_len)) |-> hi_cnt < {1'b0, pulse_len});

   assert_chip_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      t_chip_idx < t_len);

   assert_chip_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (t_run && enable && !t_start) |=> t_chip_idx >= $past(t_chip_idx));

   assert_len_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (t_run && enable && !t_start) |=> $stable(t_len));
endmodule

bind bpc_pulse_gen bpc_pulse_gen_chk #(.S_W(S_W), .CNT_W(CNT_W), .IDX_W(bpc_pkg::IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .pulse_len(pulse_len),
   .pri_len(pri_len), .sample_out(sample_out), .gate_out(gate_out),
   .t_run(t_run), .t_start(t_start), .t_chip_idx(t_chip_idx), .t_len(t_len)
);

// File: tb/sim_bpc_pulse_gen.sv
`timescale 1ns/100ps
module sim_bpc_pulse_gen;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               enable = 1'b0;
   logic [2:0]         code_sel = '0;
   logic [15:0]        tune_word = '0;
   logic [15:0]        chip_len = 16'd1;
   logic [15:0]        pulse_len = 16'd1;
   logic [15:0]        pri_len = 16'd2;
   logic signed [13:0] sample_out;
   logic               gate_out;

   int n_checks = 0;
   int n_fail   = 0;
   int per_sel [64];

   string codes [8] = '{"++", "++-", "++-+", "+++-+", "+++--+-",
                        "+++---+--+-", "+++++--++-+-+", "+++++--++-+-+"};

   always #2.5 clk = ~clk;

   bpc_pulse_gen u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .code_sel(code_sel),
      .tune_word(tune_word), .chip_len(chip_len), .pulse_len(pulse_len),
      .pri_len(pri_len), .sample_out(sample_out), .gate_out(gate_out)
   );

   function automatic int carrier(input int k, input int tw);
      int ph = (k * tw) & 16'hFFFF;
      int a  = ph >> 8;
      int u  = a % 128;
      int w  = 4 * u * (128 - u);
      if (a < 128) return (w * 8191) / 16384;
      return -((w * 8192) / 16384);
   endfunction

   task automatic check(input string tag, input logic eg, input int ev);
      n_checks++;
      if (gate_out !== eg || int'(sample_out) != ev) begin
         n_fail++;
         $display("FAIL %s%s: gate %0b sample %0d, expected gate %0b sample %0d",
                  tag, (eg ? "" : " R8"), gate_out, int'(sample_out), eg, ev);
      end
   endtask

   // Called at a falling edge with the pipeline idle.
   task automatic run_burst(input int sel0, input int sel1, input int sw,
                            input int tw, input int cl, input int pw,
                            input int pr, input int nen, input string tag);
      tune_word = 16'(tw);
      chip_len  = 16'(cl);
      pulse_len = 16'(pw);
      pri_len   = 16'(pr);
      for (int e = 0; e < nen + 4; e++) begin
         int cur = (e >= sw) ? sel1 : sel0;
         enable   = (e < nen);
         code_sel = 3'(cur);
         if (e < nen && (e % pr) == 0) per_sel[e / pr] = cur;
         @(posedge clk);
         @(negedge clk);
         begin
            int j = e - 3;
            logic eg = 1'b0;
            int ev = 0;
            if (j >= 0 && j < nen) begin
               int p = j / pr;
               int k = j % pr;
               if (k < pw) begin
                  int s   = per_sel[p];
                  int n   = codes[s].len();
                  int idx = k / cl;
                  int base;
                  if (idx > n - 1) idx = n - 1;
                  base = carrier(k, tw);
                  eg = 1'b1;
                  if (codes[s][idx] == "-") ev = (base == -8192) ? 8191 : -base;
                  else                      ev = base;
               end
            end
            check(tag, eg, ev);
         end
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      // R1: reset dominates a running configuration
      enable    = 1'b1;
      code_sel  = 3'd6;
      tune_word = 16'h1234;
      pulse_len = 16'd5;
      pri_len   = 16'd9;
      repeat (4) begin
         @(negedge clk);
         check("R1", 1'b0, 0);
      end
      enable = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", 1'b0, 0);

      // R4 R5 R6: every selection, leftover cycles extend the last chip
      for (int s = 0; s < 8; s++) begin
         int n = codes[s].len();
         run_burst(s, s, 1 << 30, 16'h0D31, 2, 2 * n + 1, 2 * n + 5, 2 * (2 * n + 5),
                   "R4 R5 R6");
      end

      // R7: negative peak lands on an inverted chip of the 13-chip code
      run_burst(6, 6, 1 << 30, 16'h4000, 1, 13, 16, 32, "R7");

      // R9: code change mid-interval applies from the next interval
      run_burst(0, 6, 3, 16'h0A00, 2, 26, 30, 90, "R9");

      // R10: abort during a pulse, then restart from phase 0
      run_burst(3, 3, 1 << 30, 16'h0731, 3, 15, 20, 7, "R10");
      run_burst(3, 3, 1 << 30, 16'h0731, 3, 15, 20, 25, "R10");

      // R3: carrier across tuning words
      for (int t = 0; t < 5; t++) begin
         int tw;
         case (t)
            0: tw = 16'h0001;
            1: tw = 16'h0100;
            2: tw = 16'h7FFF;
            3: tw = 16'h8000;
            default: tw = 16'hFFFF;
         endcase
         run_burst(5, 5, 1 << 30, tw, 3, 35, 40, 40, "R3");
      end

      // R2: pulse as long as the interval keeps the gate up across boundaries
      run_burst(1, 1, 1 << 30, 16'h0555, 4, 10, 10, 30, "R2");
      run_burst(2, 2, 1 << 30, 16'h0300, 1, 1, 3, 12, "R2");

      finish_run();
   end
endmodule